// File: doc/BRIEF.md
# Three-Wire Variable-Length Word Receiver

This block receives configuration words for a frequency synthesiser over a three-wire serial link made of an enable line, a bit clock and a data line. All three wires come from outside the system clock domain and are oversampled on the system clock. A word begins when the enable line rises. Each rising edge of the bit clock while enable stays high takes one data bit, first bit first. The receiver does not know the word length in advance. It counts the bit clocks and treats 18, 19 and 27 as the valid lengths.

The bits are committed to three separate register groups, each at its own event.
- The four band-switch bits are committed as soon as the fifth bit clock arrives.
- The 15-bit divide ratio is committed on the twentieth bit clock in long words. In 18- and 19-bit words it is committed when enable falls.
- The seven control bits are committed only when a 27-bit word ends.

The block also passes an incoming lock flag out as an active-low indicator. It holds the tuning output disabled until a divide ratio has been loaded.

Top module: `tw_word_rx`

## Requirements
- R1: After reset, band_sw is 0, div_ratio is 0, cp_hi is 1, test_bits, ref_sel_a, ref_sel_b and amp_off are 0, and tune_en is 0.
- R2: On the fifth bit clock of a word, band_sw takes the first four bits received. The first bit goes to band_sw[3] and the fourth bit to band_sw[0]. This happens before enable falls.
- R3: A word of exactly 18 bits loads div_ratio when enable falls. Bit 4 goes to div_ratio[13] and bit 17 to div_ratio[0], and div_ratio[14] is forced to 0.
- R4: A word of exactly 19 bits loads div_ratio when enable falls. Bit 4 goes to div_ratio[14] and bit 18 to div_ratio[0].
- R5: In a word of 20 bits or more, div_ratio is loaded on the twentieth bit clock, before enable falls. Bit 4 goes to div_ratio[14] and bit 18 to div_ratio[0]. Bit 19 has no effect on any output.
- R6: A word of exactly 27 bits loads the control fields when enable falls, and not earlier. Bit 20 goes to cp_hi, bits 21 to 23 go to test_bits[2:0] with bit 21 at test_bits[2], bit 24 goes to ref_sel_a, bit 25 to ref_sel_b, and bit 26 to amp_off.
- R7: A word whose count at enable fall is not 18, 19 or 27 changes nothing further at that time. A word of fewer than 5 bits changes no output at all.
- R8: Bit clock and data activity while enable is low changes no output. Each rise of enable restarts the bit count at zero.
- R9: lock_n is the inverse of lock_in, delayed by the two-stage input synchroniser.
- R10: tune_en is 0 until the first load of div_ratio, then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in | input | 1 | Word enable, high during a word |
| sck_in | input | 1 | Bit clock; data is taken on its rising edge |
| sdi_in | input | 1 | Serial data |
| lock_in | input | 1 | Loop lock flag, active high |
| band_sw | output | 4 | Band switch register |
| div_ratio | output | 15 | Programmable divide ratio |
| cp_hi | output | 1 | Charge pump high-current select |
| test_bits | output | 3 | Test mode field |
| ref_sel_a | output | 1 | Reference divider select, first bit |
| ref_sel_b | output | 1 | Reference divider select, second bit |
| amp_off | output | 1 | Tuning amplifier disable |
| tune_en | output | 1 | Tuning output enabled once a ratio is loaded |
| lock_n | output | 1 | Active-low lock indicator |

## Verification
The hardest states to reach from the ports are the ones between the mid-word commits and the end of the word. These are:
- the fifth bit clock has already written band_sw while enable is still high;
- the twentieth bit clock has already written div_ratio while the control fields still hold their old value.

The bench reaches them by driving each word bit by bit and pausing after the fifth and twentieth bit clocks, before enable falls, to compare the outputs against a running model. Odd lengths (3, 10, 22 and 30 bits) and bit-clock activity with enable low are also driven. These show that only the edge-triggered commits take effect for them.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int SW_W      = 4;
    localparam int RATIO_W   = 15;
    localparam int TST_W     = 3;
    localparam int LEN_SHORT = 18;
    localparam int LEN_MID   = 19;
    localparam int LEN_LONG  = 27;

    // Control fields, most significant member is the earliest received bit.
    typedef struct packed {
        logic             cp;
        logic [TST_W-1:0] tst;
        logic             rs_a;
        logic             rs_b;
        logic             amp_off;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d = {st_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];

endmodule

// File: rtl/twr_shifter.sv
module twr_shifter #(
    parameter int SHIFT_W = 19,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_s,
    input  logic               sck_s,
    input  logic               sdi_s,
    output logic               bit_stb,
    output logic               ce_fall,
    output logic [CNT_W-1:0]   cnt,
    output logic [SHIFT_W-1:0] shreg
);

    typedef struct packed {
        logic               ce_prev;
        logic               sck_prev;
        logic [CNT_W-1:0]   cnt;
        logic [SHIFT_W-1:0] sh;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic      ce_rise;

    always_comb begin
        st_d          = st_q;
        st_d.ce_prev  = ce_s;
        st_d.sck_prev = sck_s;
        ce_rise = ce_s & ~st_q.ce_prev;
        ce_fall = ~ce_s & st_q.ce_prev;
        bit_stb = sck_s & ~st_q.sck_prev & ce_s & st_q.ce_prev;
        if (ce_rise) begin
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (bit_stb) begin
            st_d.sh = {st_q.sh[SHIFT_W-2:0], sdi_s};
            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign shreg = st_q.sh;

    // R8: a new word always starts counting from zero
    p_count_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rise |=> (cnt == '0));

    // R8: the count only moves on a bit clock or a word start
    p_count_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !ce_rise) |=> $stable(cnt));

endmodule

// File: rtl/tw_word_rx.sv
module tw_word_rx #(
    parameter int SW_W      = twr_pkg::SW_W,
    parameter int RATIO_W   = twr_pkg::RATIO_W,
    parameter int TST_W     = twr_pkg::TST_W,
    parameter int LEN_SHORT = twr_pkg::LEN_SHORT,
    parameter int LEN_MID   = twr_pkg::LEN_MID,
    parameter int LEN_LONG  = twr_pkg::LEN_LONG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_in,
    input  logic               sck_in,
    input  logic               sdi_in,
    input  logic               lock_in,
    output logic [SW_W-1:0]    band_sw,
    output logic [RATIO_W-1:0] div_ratio,
    output logic               cp_hi,
    output logic [TST_W-1:0]   test_bits,
    output logic               ref_sel_a,
    output logic               ref_sel_b,
    output logic               amp_off,
    output logic               tune_en,
    output logic               lock_n
);

    import twr_pkg::*;

    localparam int SHIFT_W = LEN_MID;
    localparam int CNT_W   = $clog2(LEN_LONG + 1);
    localparam logic [CNT_W-1:0] CNT_SW    = CNT_W'(SW_W);
    localparam logic [CNT_W-1:0] CNT_FREQ  = CNT_W'(LEN_MID);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(LEN_SHORT);
    localparam logic [CNT_W-1:0] CNT_MID   = CNT_W'(LEN_MID);
    localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LEN_LONG);
    localparam ctrl_t CTRL_RST = '{cp: 1'b1, tst: '0, rs_a: 1'b0, rs_b: 1'b0, amp_off: 1'b0};

    logic [3:0]         raw_in, sync_out;
    logic               ce_s, sck_s, sdi_s, lock_s;
    logic               bit_stb, ce_fall;
    logic [CNT_W-1:0]   cnt;
    logic [SHIFT_W-1:0] shreg;

    assign raw_in = {ce_in, sck_in, sdi_in, lock_in};
    assign {ce_s, sck_s, sdi_s, lock_s} = sync_out;

    twr_sync #(.W(4), .STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_out)
    );

    twr_shifter #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ce_s),
        .sck_s   (sck_s),
        .sdi_s   (sdi_s),
        .bit_stb (bit_stb),
        .ce_fall (ce_fall),
        .cnt     (cnt),
        .shreg   (shreg)
    );

    typedef struct packed {
        logic [SW_W-1:0]    sw;
        logic [RATIO_W-1:0] ratio;
        ctrl_t              ctrl;
        logic               tune;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_stb) begin
            if (cnt == CNT_SW) st_d.sw = shreg[SW_W-1:0];
            if (cnt == CNT_FREQ) begin
                st_d.ratio = shreg[RATIO_W-1:0];
                st_d.tune  = 1'b1;
            end
        end
        if (ce_fall) begin
            if (cnt == CNT_SHORT) begin
                st_d.ratio = {1'b0, shreg[RATIO_W-2:0]};
                st_d.tune  = 1'b1;
            end else if (cnt == CNT_MID) begin
                st_d.ratio = shreg[RATIO_W-1:0];
                st_d.tune  = 1'b1;
            end else if (cnt == CNT_LONG) begin
                st_d.ctrl = ctrl_t'(shreg[CTRL_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sw    <= '0;
            st_q.ratio <= '0;
            st_q.ctrl  <= CTRL_RST;
            st_q.tune  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign band_sw   = st_q.sw;
    assign div_ratio = st_q.ratio;
    assign cp_hi     = st_q.ctrl.cp;
    assign test_bits = st_q.ctrl.tst;
    assign ref_sel_a = st_q.ctrl.rs_a;
    assign ref_sel_b = st_q.ctrl.rs_b;
    assign amp_off   = st_q.ctrl.amp_off;
    assign tune_en   = st_q.tune;
    assign lock_n    = ~lock_s;

    // R2: switch bits change only right after the fifth bit clock
    p_sw_fifth_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sw) |-> $past(bit_stb && cnt == CNT_SW));

    // R6: control fields change only at the end of a long word
    p_ctrl_long_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ctrl) |-> $past(ce_fall && cnt == CNT_LONG));

    // R7: the ratio changes only at its three legal events
    p_ratio_events_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ratio) |-> $past((bit_stb && cnt == CNT_FREQ) ||
                                       (ce_fall && (cnt == CNT_SHORT || cnt == CNT_MID))));

    // R3: a short word leaves the top ratio bit clear
    p_short_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_fall && cnt == CNT_SHORT) |-> !div_ratio[RATIO_W-1]);

    // R5: the twentieth bit clock copies the held bits into the ratio
    p_ratio_mid_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_stb && cnt == CNT_FREQ) |-> div_ratio == $past(shreg[RATIO_W-1:0]));

    // R10: once enabled, tuning stays enabled
    p_tune_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(tune_en));

endmodule

// File: tb/test_tw_word_rx.sv
module test_tw_word_rx;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam int NVEC       = 8;

    localparam logic [4:0]  V_LEN  [NVEC] = '{5'd27, 5'd18, 5'd19, 5'd3, 5'd10, 5'd22, 5'd30, 5'd27};
    localparam logic [26:0] V_BITS [NVEC] = '{27'h5B3C2E9, 27'h7FFFFFF, 27'h2C81A4F, 27'h7FFFFFF,
                                              27'h1234567, 27'h6F0F0F0, 27'h3333333, 27'h0ABCDEF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_in = 1'b0, sck_in = 1'b0, sdi_in = 1'b0, lock_in = 1'b0;
    logic [3:0]  band_sw;
    logic [14:0] div_ratio;
    logic        cp_hi, ref_sel_a, ref_sel_b, amp_off, tune_en, lock_n;
    logic [2:0]  test_bits;

    int n_chk = 0, n_fail = 0;
    logic [3:0]  m_sw;
    logic [14:0] m_ratio;
    logic [6:0]  m_ctrl;
    logic        m_tune;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_word_rx i_tw_word_rx (
        .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .sck_in(sck_in), .sdi_in(sdi_in),
        .lock_in(lock_in), .band_sw(band_sw), .div_ratio(div_ratio), .cp_hi(cp_hi),
        .test_bits(test_bits), .ref_sel_a(ref_sel_a), .ref_sel_b(ref_sel_b),
        .amp_off(amp_off), .tune_en(tune_en), .lock_n(lock_n)
    );

    function automatic logic [6:0] ctrl_out();
        return {cp_hi, test_bits, ref_sel_a, ref_sel_b, amp_off};
    endfunction

    function automatic logic bit_of(logic [26:0] w, int i);
        return (i < 27) ? w[26-i] : 1'b0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(string req);
        check({req, " sw"},    32'(band_sw),    32'(m_sw));
        check({req, " ratio"}, 32'(div_ratio),  32'(m_ratio));
        check({req, " ctrl"},  32'(ctrl_out()), 32'(m_ctrl));
        check({req, " tune"},  32'(tune_en),    32'(m_tune));
    endtask

    task automatic send_word(int len, logic [26:0] w);
        ce_in = 1'b1;
        wait_clk(HALF_BIT);
        for (int i = 0; i < len; i++) begin
            sdi_in = bit_of(w, i);
            sck_in = 1'b0;
            wait_clk(HALF_BIT);
            sck_in = 1'b1;
            wait_clk(HALF_BIT + 2);
            if (i == 4) begin
                m_sw = {bit_of(w, 0), bit_of(w, 1), bit_of(w, 2), bit_of(w, 3)};
                check("R2 switch at fifth clock", 32'(band_sw), 32'(m_sw));
            end
            if (i == 19) begin
                for (int k = 0; k < 15; k++) m_ratio[14-k] = bit_of(w, 4 + k);
                m_tune = 1'b1;
                check("R5 ratio at twentieth clock", 32'(div_ratio), 32'(m_ratio));
                check("R6 ctrl held before word end", 32'(ctrl_out()), 32'(m_ctrl));
            end
        end
        sck_in = 1'b0;
        wait_clk(HALF_BIT);
        ce_in = 1'b0;
        wait_clk(8);
        if (len == 18) begin
            m_ratio[14] = 1'b0;
            for (int k = 0; k < 14; k++) m_ratio[13-k] = bit_of(w, 4 + k);
            m_tune = 1'b1;
        end else if (len == 19) begin
            for (int k = 0; k < 15; k++) m_ratio[14-k] = bit_of(w, 4 + k);
            m_tune = 1'b1;
        end else if (len == 27) begin
            for (int k = 0; k < 7; k++) m_ctrl[6-k] = bit_of(w, 20 + k);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        m_sw = '0; m_ratio = '0; m_ctrl = 7'b1000000; m_tune = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        check_all("R1 reset");
        check("R9 lock idle", 32'(lock_n), 32'd1);

        // R8: activity with enable low
        for (int t = 0; t < 12; t++) begin
            sdi_in = t[0];
            sck_in = ~sck_in;
            wait_clk(HALF_BIT);
        end
        sck_in = 1'b0;
        wait_clk(6);
        check_all("R8 enable low ignored");

        for (int v = 0; v < NVEC; v++) begin
            send_word(int'(V_LEN[v]), V_BITS[v]);
            case (int'(V_LEN[v]))
                18:      check_all("R3 short word");
                19:      check_all("R4 mid word");
                27:      check_all("R6 long word");
                3:       check_all("R7 tiny word");
                default: check_all("R7 odd length word");
            endcase
        end

        // R8: idle clocks after a word, then a fresh word restarts the count
        for (int t = 0; t < 6; t++) begin
            sck_in = ~sck_in;
            wait_clk(HALF_BIT);
        end
        sck_in = 1'b0;
        wait_clk(4);
        check_all("R8 idle after word");
        send_word(19, 27'h15A5A5A);
        check_all("R8 restart count R4");

        // R9: lock flag
        lock_in = 1'b1;
        wait_clk(4);
        check("R9 lock asserted", 32'(lock_n), 32'd0);
        lock_in = 1'b0;
        wait_clk(4);
        check("R9 lock released", 32'(lock_n), 32'd1);

        // R10: reset clears tuning enable again
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        m_sw = '0; m_ratio = '0; m_ctrl = 7'b1000000; m_tune = 1'b0;
        wait_clk(3);
        check_all("R10 R1 after second reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule